// File: doc/BRIEF.md
# Packed Decimal Byte Arithmetic Unit

This unit does decimal arithmetic on one byte that holds two packed BCD digits. It can add a source byte to a destination byte, subtract the source from the destination, or negate the destination. In each case the incoming extend bit takes part as a carry for add, or as a borrow for subtract and negate. The result byte and the new flags are registered one clock after a start strobe, and a done pulse marks them valid.

Numbers wider than one byte are processed one byte per operation, starting with the least significant byte. Between bytes the caller feeds the returned extend and zero flags back into the unit. Before the first byte the caller sets extend to 0 and zero to 1. The zero flag can only be cleared, never set. After the last byte it is therefore 1 only if every byte of the chained result was zero.

Top module: `bcd_byte_alu`

## Requirements
- R1: While `rst` is high, and after it falls until the first start, `result`, `x_out`, `c_out`, `z_out` and `done` are all 0.
- R2: With `op` = 2'b00 (add) and valid BCD operands, `result` is the two-digit decimal value of (dst + src + x_in) mod 100.
- R3: With `op` = 2'b01 (subtract) and valid BCD operands, `result` is the two-digit decimal value of (dst − src − x_in) mod 100.
- R4: With `op[1]` = 1 (negate), `result` is the two-digit decimal value of (0 − dst − x_in) mod 100, and `src` has no effect.
- R5: `c_out` and `x_out` are always equal. They are 1 exactly when the decimal sum reaches 100 (add), or when the decimal difference is below 0 (subtract or negate).
- R6: `z_out` is 0 when the result byte is non-zero and equals `z_in` when the result byte is zero.
- R7: `result` and the flags update on the clock edge that samples `start` high, and `done` is high for exactly that following cycle. Outputs hold when `start` is low.
- R8: Operands that contain the digits A to F still give a `done` pulse one cycle after start and outputs with no unknown bits.
- R9: Several bytes processed low-order first, with `x_out` and `z_out` fed back into `x_in` and `z_in`, give the correct multi-digit decimal sum or difference, the final carry or borrow, and a zero flag that is 1 only for an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation on the current inputs |
| op | input | 2 | 00 add, 01 subtract, 1x negate |
| src | input | 8 | Source byte, two packed BCD digits |
| dst | input | 8 | Destination byte, two packed BCD digits |
| x_in | input | 1 | Incoming extend flag (carry or borrow in) |
| z_in | input | 1 | Incoming zero flag |
| result | output | 8 | Registered decimal result byte |
| x_out | output | 1 | Updated extend flag |
| c_out | output | 1 | Updated carry flag |
| z_out | output | 1 | Updated zero flag |
| done | output | 1 | One-cycle pulse marking the result valid |

## Verification
The case that is hardest to reach is the sticky zero flag across a chain. Within one chain, some bytes must come out zero and others non-zero, and in some chains a zero low byte must carry into a non-zero upper byte. Random single-byte operations almost never produce a zero result with `z_in` low, or a result of exactly 00 together with a carry. The bench therefore runs directed three-byte chains that feed `x_out` and `z_out` back in, with these cases: all zero; 995000 + 005000, which is zero with a carry; a zero low part under a non-zero top byte; and a non-zero middle byte under zero ends. Random operations with valid digits and random `z_in` cover the single-byte paths.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned NIB_W = 4;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_NEG = 2'b10,
    OP_NG2 = 2'b11
  } bcd_op_e;
endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add #(
  parameter int unsigned NW = 4
) (
  input  logic [NW-1:0] a,
  input  logic [NW-1:0] b,
  input  logic          cin,
  output logic [NW-1:0] sum,
  output logic          cout
);
  logic [NW:0] raw;
  always_comb begin
    raw  = {1'b0, a} + {1'b0, b} + {{NW{1'b0}}, cin};
    cout = (raw > (NW+1)'(9));
    sum  = cout ? (raw[NW-1:0] + NW'(6)) : raw[NW-1:0];
  end
endmodule

// File: rtl/bcd_digit_sub.sv
module bcd_digit_sub #(
  parameter int unsigned NW = 4
) (
  input  logic [NW-1:0] a,
  input  logic [NW-1:0] b,
  input  logic          bin,
  output logic [NW-1:0] diff,
  output logic          bout
);
  logic [NW:0] raw;
  always_comb begin
    raw  = {1'b0, a} - {1'b0, b} - {{NW{1'b0}}, bin};
    bout = raw[NW];
    diff = bout ? (raw[NW-1:0] - NW'(6)) : raw[NW-1:0];
  end
endmodule

// File: rtl/bcd_byte_core.sv
module bcd_byte_core
  import bcd_pkg::*;
#(
  parameter int unsigned DIGITS = 2,
  localparam int unsigned W = DIGITS * NIB_W
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  input  logic         xin,
  output logic [W-1:0] res,
  output logic         cy
);
  logic [DIGITS:0]  add_c;
  logic [DIGITS:0]  sub_c;
  logic [W-1:0]     add_r;
  logic [W-1:0]     sub_r;
  logic [W-1:0]     sub_a;
  logic [W-1:0]     sub_b;
  logic             is_neg;

  assign is_neg   = op[1];
  assign sub_a    = is_neg ? '0 : dst;
  assign sub_b    = is_neg ? dst : src;
  assign add_c[0] = xin;
  assign sub_c[0] = xin;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    bcd_digit_add #(.NW(NIB_W)) u_add (
      .a   (dst[g*NIB_W +: NIB_W]),
      .b   (src[g*NIB_W +: NIB_W]),
      .cin (add_c[g]),
      .sum (add_r[g*NIB_W +: NIB_W]),
      .cout(add_c[g+1])
    );
    bcd_digit_sub #(.NW(NIB_W)) u_sub (
      .a   (sub_a[g*NIB_W +: NIB_W]),
      .b   (sub_b[g*NIB_W +: NIB_W]),
      .bin (sub_c[g]),
      .diff(sub_r[g*NIB_W +: NIB_W]),
      .bout(sub_c[g+1])
    );
  end

  always_comb begin
    if (op == OP_ADD) begin
      res = add_r;
      cy  = add_c[DIGITS];
    end else begin
      res = sub_r;
      cy  = sub_c[DIGITS];
    end
  end
endmodule

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu
  import bcd_pkg::*;
#(
  parameter int unsigned DIGITS = 2,
  localparam int unsigned W = DIGITS * NIB_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  input  logic         x_in,
  input  logic         z_in,
  output logic [W-1:0] result,
  output logic         x_out,
  output logic         c_out,
  output logic         z_out,
  output logic         done
);
  logic [W-1:0] core_res;
  logic         core_cy;

  bcd_byte_core #(.DIGITS(DIGITS)) u_core (
    .op (op),
    .src(src),
    .dst(dst),
    .xin(x_in),
    .res(core_res),
    .cy (core_cy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      x_out  <= 1'b0;
      c_out  <= 1'b0;
      z_out  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        result <= core_res;
        x_out  <= core_cy;
        c_out  <= core_cy;
        z_out  <= (core_res != '0) ? 1'b0 : z_in;
      end
    end
  end
endmodule

// File: rtl/bcd_byte_alu_chk.sv
module bcd_byte_alu_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         z_in,
  input logic [W-1:0] result,
  input logic         x_out,
  input logic         c_out,
  input logic         z_out,
  input logic         done
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (result == '0 && !done && !x_out && !c_out && !z_out));

  a_r5_c_eq_x: assert property (@(posedge clk) disable iff (rst)
    x_out == c_out);

  a_r6_z_never_set: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(z_in)) |-> !z_out);

  a_r6_nonzero_clears: assert property (@(posedge clk) disable iff (rst)
    (done && result != '0) |-> !z_out);

  a_r7_done_follows: assert property (@(posedge clk) disable iff (rst)
    start |=> done);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(start) |-> ($stable(result) && $stable(z_out) && $stable(c_out)));
endmodule

bind bcd_byte_alu bcd_byte_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .z_in(z_in), .result(result),
  .x_out(x_out), .c_out(c_out), .z_out(z_out), .done(done)
);

// File: tb/bcd_byte_alu_tb.sv
`timescale 1ns/1ps
module bcd_byte_alu_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] src = 8'h00;
  logic [7:0] dst = 8'h00;
  logic       x_in = 1'b0;
  logic       z_in = 1'b1;
  logic [7:0] result;
  logic       x_out, c_out, z_out, done;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bcd_byte_alu u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .src(src), .dst(dst),
    .x_in(x_in), .z_in(z_in), .result(result), .x_out(x_out),
    .c_out(c_out), .z_out(z_out), .done(done)
  );

  function automatic int b2i(input logic [7:0] b);
    return b[7:4] * 10 + b[3:0];
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [7:0] rand_bcd();
    return i2b(int'($urandom_range(0, 99)));
  endfunction

  // reference: returns {carry, result byte}
  function automatic logic [8:0] model(input logic [1:0] o, input logic [7:0] s,
                                       input logic [7:0] d, input logic x);
    int v;
    if (o == 2'b00) v = b2i(d) + b2i(s) + int'(x);
    else if (o == 2'b01) v = b2i(d) - b2i(s) - int'(x);
    else v = 0 - b2i(d) - int'(x);
    if (v >= 100) return {1'b1, i2b(v - 100)};
    if (v < 0) return {1'b1, i2b(v + 100)};
    return {1'b0, i2b(v)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply one op; outputs sampled at the negedge after the capturing edge
  task automatic run_op(input logic [1:0] o, input logic [7:0] s, input logic [7:0] d,
                        input logic x, input logic z);
    @(negedge clk);
    op = o; src = s; dst = d; x_in = x; z_in = z; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic op_check(input string req, input logic [1:0] o, input logic [7:0] s,
                          input logic [7:0] d, input logic x, input logic z);
    logic [8:0] m;
    m = model(o, s, d, x);
    run_op(o, s, d, x, z);
    check({req, " result"}, 32'(result), 32'(m[7:0]));
    check("R5 carry", 32'(c_out), 32'(m[8]));
    check("R5 x equals c", 32'(x_out), 32'(c_out));
    check("R6 zero", 32'(z_out), 32'((m[7:0] != 8'h00) ? 1'b0 : z));
    check("R7 done", 32'(done), 32'd1);
  endtask

  // three-byte chain, low byte first; a,b given as 6-digit decimal
  task automatic chain(input logic [1:0] o, input int a, input int b);
    int exp_v, ai, bi;
    logic cy, zf, ecy;
    logic [23:0] got;
    cy = 1'b0; zf = 1'b1; ai = a; bi = b;
    for (int k = 0; k < 3; k++) begin
      run_op(o, i2b(bi % 100), i2b(ai % 100), cy, zf);
      got[k*8 +: 8] = result;
      cy = x_out; zf = z_out;
      ai = ai / 100; bi = bi / 100;
    end
    exp_v = (o == 2'b00) ? a + b : a - b;
    ecy = 1'b0;
    if (exp_v >= 1000000) begin exp_v -= 1000000; ecy = 1'b1; end
    if (exp_v < 0) begin exp_v += 1000000; ecy = 1'b1; end
    check("R9 chain value", 32'(got),
          32'({i2b(exp_v / 10000), i2b((exp_v / 100) % 100), i2b(exp_v % 100)}));
    check("R9 chain carry", 32'(cy), 32'(ecy));
    check("R9 chain zero", 32'(zf), 32'(exp_v == 0));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] keep;
    void'($urandom(32'h5EED_BCD1));
    repeat (3) @(negedge clk);
    check("R1 reset result", 32'(result), 0);
    check("R1 reset flags", 32'({x_out, c_out, z_out, done}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", 32'({result, x_out, c_out, z_out, done}), 0);

    // directed corners
    op_check("R2", 2'b00, 8'h99, 8'h99, 1'b1, 1'b1);   // 199 -> 99 carry
    op_check("R2", 2'b00, 8'h01, 8'h99, 1'b0, 1'b1);   // 00 carry, z kept
    op_check("R2", 2'b00, 8'h00, 8'h00, 1'b0, 1'b0);   // zero, z stays 0
    op_check("R2", 2'b00, 8'h05, 8'h05, 1'b0, 1'b1);   // low digit adjust
    op_check("R3", 2'b01, 8'h01, 8'h00, 1'b0, 1'b1);   // borrow -> 99
    op_check("R3", 2'b01, 8'h09, 8'h10, 1'b1, 1'b1);   // 00, no borrow
    op_check("R3", 2'b01, 8'h99, 8'h00, 1'b1, 1'b0);   // 00 borrow
    op_check("R4", 2'b10, 8'h55, 8'h00, 1'b0, 1'b1);   // -0 = 0 no borrow
    op_check("R4", 2'b11, 8'h12, 8'h00, 1'b1, 1'b1);   // -1 -> 99
    op_check("R4", 2'b10, 8'h00, 8'h37, 1'b0, 1'b1);   // 63 borrow

    // R4 src has no effect on negate
    run_op(2'b10, 8'h00, 8'h42, 1'b0, 1'b1);
    keep = result;
    run_op(2'b10, 8'hFF, 8'h42, 1'b0, 1'b1);
    check("R4 src ignored", 32'(result), 32'(keep));

    // R7 pulse width and hold
    run_op(2'b00, 8'h11, 8'h22, 1'b0, 1'b1);
    keep = result;
    @(negedge clk);
    check("R7 done single cycle", 32'(done), 0);
    src = 8'h44; dst = 8'h44;
    @(negedge clk);
    check("R7 hold result", 32'(result), 32'(keep));

    // R8 invalid digits
    run_op(2'b00, 8'hFA, 8'hBC, 1'b1, 1'b1);
    check("R8 done on invalid", 32'(done), 1);
    check("R8 known outputs", 32'(^{result, x_out, c_out, z_out} === 1'bx), 0);
    run_op(2'b01, 8'hEE, 8'h0F, 1'b0, 1'b0);
    check("R8 done on invalid sub", 32'(done), 1);
    check("R8 known outputs sub", 32'(^{result, x_out, c_out, z_out} === 1'bx), 0);

    // R9 chains
    chain(2'b00, 0, 0);
    chain(2'b00, 995000, 5000);
    chain(2'b00, 10000, 0);
    chain(2'b00, 100, 0);
    chain(2'b01, 100000, 1);
    chain(2'b01, 0, 1);
    chain(2'b01, 123456, 123456);

    // random R2/R3/R4
    for (int i = 0; i < 300; i++) begin
      logic [1:0] ro;
      ro = 2'($urandom_range(0, 3));
      op_check(ro == 2'b00 ? "R2" : (ro == 2'b01 ? "R3" : "R4"),
               ro, rand_bcd(), rand_bcd(), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)));
    end
    for (int i = 0; i < 10; i++)
      chain(2'($urandom_range(0, 1)), int'($urandom_range(0, 999999)),
            int'($urandom_range(0, 999999)));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule